// File: doc/BRIEF.md
# Capability indirect jump target unit

This block handles the target side of a capability-mode indirect jump-and-link. It takes a source capability, meaning an address, a base, a top, a sealed flag and a tag, together with a 12-bit signed offset and the current program-counter capability. It computes where the jump lands, checks that this point lies within the source bounds, and produces two results: the replacement program-counter capability and a sealed return-link capability for the destination register.

The steps run in a fixed order. The source capability is unsealed first. The offset is then added and bit 0 is cleared. Next, an out-of-range address is folded back into the virtual address space, when that feature is enabled. Last, the folded address is checked against the unmodified bounds. No separate representability test and no sealed test are made, because neither could fail at that point.

All results appear one clock after the request, with a one-cycle valid pulse. A fault suppresses both register write enables and reports a cause code.

Top module: `cjt_unit`

## Requirements
- R1: The target address is the source address plus the immediate sign-extended to XLEN bits, modulo 2^XLEN, with bit 0 then forced to 0.
- R2: With CONV_EN set, a target whose bits XLEN-1..VAW are not all equal to bit VAW-1 has those bits replaced by copies of bit VAW-1. A target whose upper bits already match is left unchanged.
- R3: A length fault is declared when the converted target is below the source base, or when the target plus 4 (computed without wrap) exceeds the source top. It reports cause 2'b10, with the exception flag high and both write enables low.
- R4: A cleared source tag reports cause 2'b01 with both write enables low. This cause takes priority over a length fault.
- R5: A sealed source is jumped to like an unsealed one, and the new program-counter capability always has its sealed flag 0.
- R6: On success the new program-counter capability carries the source base and top unchanged, and the program-counter write enable is 1.
- R7: On success the link capability holds the current program-counter address plus 4 (modulo 2^XLEN) and the current program-counter bounds, with its sealed flag 1 and its write enable 1. Cause is 2'b00 and the exception flag is 0.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. When it is low, both write enables and the exception flag are low. Reset clears out_valid, the write enables and the exception flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_addr | input | XLEN | Source capability address |
| src_base | input | XLEN | Source capability lower bound |
| src_top | input | XLEN | Source capability upper bound (exclusive) |
| src_sealed | input | 1 | Source sealed flag |
| src_tag | input | 1 | Source tag (validity) |
| imm | input | 12 | Signed jump offset |
| pcc_addr | input | XLEN | Current program-counter address |
| pcc_base | input | XLEN | Current program-counter lower bound |
| pcc_top | input | XLEN | Current program-counter upper bound |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_exc | output | 1 | Exception raised |
| out_cause | output | 2 | 00 none, 01 tag fault, 10 length fault |
| out_pc_we | output | 1 | Program-counter update enable |
| out_pc_addr | output | XLEN | New program-counter address |
| out_pc_base | output | XLEN | New program-counter lower bound |
| out_pc_top | output | XLEN | New program-counter upper bound |
| out_pc_sealed | output | 1 | New program-counter sealed flag |
| out_link_we | output | 1 | Destination write enable |
| out_link_addr | output | XLEN | Link address |
| out_link_base | output | XLEN | Link lower bound |
| out_link_top | output | XLEN | Link upper bound |
| out_link_sealed | output | 1 | Link sealed flag |

## Verification
The bench builds the unit with XLEN=16, VAW=10 and conversion enabled. With these values the valid address space is only the two 512-byte windows at the ends of the map. That makes it cheap to sweep every one of the 4096 offsets from several source addresses.

The starting points sit just inside a window edge, inside the upper window, and in the invalid gap. Between them, the sweep crosses from valid into invalid addresses and back, wraps modulo 2^16, and lands on tight bounds on both sides. Tag and sealed flags vary along the sweep, so tag priority and the sealed-source case are exercised across every branch.

// File: rtl/cjt_pkg.sv
// Shared types and constants for the capability jump target unit.
package cjt_pkg;
    localparam int unsigned CJT_IMM_W      = 12;
    localparam int unsigned CJT_INSN_BYTES = 4;

    typedef enum logic [1:0] {
        CJT_OK  = 2'b00,
        CJT_TAG = 2'b01,
        CJT_LEN = 2'b10
    } cjt_cause_e;
endpackage

// File: rtl/cjt_target.sv
// Forms the jump target: source address plus sign-extended offset, bit 0
// cleared, then optional folding of out-of-range upper bits.
// Assumes VAW <= XLEN and XLEN > immediate width.
module cjt_target #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned VAW     = 24,
    parameter bit          CONV_EN = 1'b1
) (
    input  logic [XLEN-1:0]               src_addr,
    input  logic [cjt_pkg::CJT_IMM_W-1:0] imm,
    output logic [XLEN-1:0]               tgt_addr
);
    localparam int unsigned EXT_W = XLEN - cjt_pkg::CJT_IMM_W;

    logic [XLEN-1:0] sum;

    // Offset add with sign extension, then clear bit 0.
    always_comb begin
        sum    = src_addr + {{EXT_W{imm[cjt_pkg::CJT_IMM_W-1]}}, imm};
        sum[0] = 1'b0;
    end

    generate
        if (CONV_EN && (VAW < XLEN)) begin : g_conv
            localparam int unsigned UP_W = XLEN - VAW;
            // Fold: upper bits become copies of the top valid bit.
            always_comb tgt_addr = {{UP_W{sum[VAW-1]}}, sum[VAW-1:0]};
        end else begin : g_pass
            // No folding configured.
            always_comb tgt_addr = sum;
        end
    endgenerate
endmodule

// File: rtl/cjt_bounds.sv
// Length check of a jump target against unmodified bounds: the address must
// be at or above base and a full minimum-size instruction must fit below top.
module cjt_bounds #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] top,
    output logic            len_bad
);
    logic [XLEN:0] end_addr;

    // Compare with one extra bit so the end address cannot wrap.
    always_comb begin
        end_addr = {1'b0, addr} + (XLEN+1)'(cjt_pkg::CJT_INSN_BYTES);
        len_bad  = (addr < base) || (end_addr > {1'b0, top});
    end
endmodule

// File: rtl/cjt_unit.sv
// Capability indirect jump target unit. Unseals the source, forms and folds
// the target, checks tag then length, and registers the new program-counter
// capability, the sealed link and the fault cause one cycle after in_valid.
// Assumes the caller applies the write enables only when out_valid is high.
module cjt_unit #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned VAW     = 24,
    parameter bit          CONV_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] src_addr,
    input  logic [XLEN-1:0] src_base,
    input  logic [XLEN-1:0] src_top,
    input  logic            src_sealed,
    input  logic            src_tag,
    input  logic [11:0]     imm,
    input  logic [XLEN-1:0] pcc_addr,
    input  logic [XLEN-1:0] pcc_base,
    input  logic [XLEN-1:0] pcc_top,
    output logic            out_valid,
    output logic            out_exc,
    output logic [1:0]      out_cause,
    output logic            out_pc_we,
    output logic [XLEN-1:0] out_pc_addr,
    output logic [XLEN-1:0] out_pc_base,
    output logic [XLEN-1:0] out_pc_top,
    output logic            out_pc_sealed,
    output logic            out_link_we,
    output logic [XLEN-1:0] out_link_addr,
    output logic [XLEN-1:0] out_link_base,
    output logic [XLEN-1:0] out_link_top,
    output logic            out_link_sealed
);
    import cjt_pkg::*;

    logic [XLEN-1:0] tgt_addr;
    logic            len_bad;
    logic            tgt_sealed;
    cjt_cause_e      cause_c;
    logic [XLEN-1:0] link_addr_c;

    cjt_target #(.XLEN(XLEN), .VAW(VAW), .CONV_EN(CONV_EN)) u_target (
        .src_addr (src_addr),
        .imm      (imm),
        .tgt_addr (tgt_addr)
    );

    cjt_bounds #(.XLEN(XLEN)) u_bounds (
        .addr    (tgt_addr),
        .base    (src_base),
        .top     (src_top),
        .len_bad (len_bad)
    );

    // Unseal step: the target seal is cleared whatever the source held.
    assign tgt_sealed = src_sealed & 1'b0;

    // Fault selection: tag fault outranks length fault.
    always_comb begin
        if (!src_tag)     cause_c = CJT_TAG;
        else if (len_bad) cause_c = CJT_LEN;
        else              cause_c = CJT_OK;
    end

    // Return address: next sequential instruction after the jump.
    assign link_addr_c = pcc_addr + XLEN'(CJT_INSN_BYTES);

    // Control register stage: strobe, fault flag and write enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_exc     <= 1'b0;
            out_cause   <= CJT_OK;
            out_pc_we   <= 1'b0;
            out_link_we <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_exc     <= in_valid && (cause_c != CJT_OK);
            out_cause   <= in_valid ? cause_c : CJT_OK;
            out_pc_we   <= in_valid && (cause_c == CJT_OK);
            out_link_we <= in_valid && (cause_c == CJT_OK);
        end
    end

    // Data register stage: capability fields captured on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pc_addr     <= '0;
            out_pc_base     <= '0;
            out_pc_top      <= '0;
            out_pc_sealed   <= 1'b0;
            out_link_addr   <= '0;
            out_link_base   <= '0;
            out_link_top    <= '0;
            out_link_sealed <= 1'b0;
        end else if (in_valid) begin
            out_pc_addr     <= tgt_addr;
            out_pc_base     <= src_base;
            out_pc_top      <= src_top;
            out_pc_sealed   <= tgt_sealed;
            out_link_addr   <= link_addr_c;
            out_link_base   <= pcc_base;
            out_link_top    <= pcc_top;
            out_link_sealed <= 1'b1;
        end
    end
endmodule

// File: rtl/cjt_unit_chk.sv
// Checker for cjt_unit, attached by bind. Observes ports only and relates
// outputs to inputs of the previous cycle once a cycle has passed after reset.
module cjt_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            src_tag,
    input logic [XLEN-1:0] pcc_addr,
    input logic            out_valid,
    input logic            out_exc,
    input logic [1:0]      out_cause,
    input logic            out_pc_we,
    input logic [XLEN-1:0] out_pc_addr,
    input logic [XLEN-1:0] out_pc_base,
    input logic [XLEN-1:0] out_pc_top,
    input logic            out_link_we,
    input logic [XLEN-1:0] out_link_addr,
    input logic            out_link_sealed
);
    logic armed;

    // Marks that one full cycle out of reset has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_pc_we && !out_link_we && !out_exc));

    // R3
    fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_exc |-> (!out_pc_we && !out_link_we && out_cause != 2'b00));

    // R4
    tag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && !$past(src_tag)) |-> (out_cause == 2'b01));

    // R1
    even_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_pc_we |-> !out_pc_addr[0]);

    // R3
    in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_pc_we |-> ((out_pc_addr >= out_pc_base) &&
                       (({1'b0, out_pc_addr} + (XLEN+1)'(4)) <= {1'b0, out_pc_top})));

    // R7
    link_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_link_we) |-> (out_link_addr == $past(pcc_addr) + XLEN'(4)
                                    && out_link_sealed && out_pc_we));
endmodule

bind cjt_unit cjt_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_cjt_unit.sv
`timescale 1ns/1ps
module tb_cjt_unit;
    localparam int XW  = 16;
    localparam int VW  = 10;
    localparam int NSET = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [XW-1:0] src_addr = '0, src_base = '0, src_top = '0;
    logic          src_sealed = 1'b0, src_tag = 1'b0;
    logic [11:0]   imm = '0;
    logic [XW-1:0] pcc_addr = '0, pcc_base = '0, pcc_top = '0;
    logic          out_valid, out_exc, out_pc_we, out_pc_sealed, out_link_we, out_link_sealed;
    logic [1:0]    out_cause;
    logic [XW-1:0] out_pc_addr, out_pc_base, out_pc_top;
    logic [XW-1:0] out_link_addr, out_link_base, out_link_top;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    cjt_unit #(.XLEN(XW), .VAW(VW), .CONV_EN(1'b1)) dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected target per R1 and R2.
    function automatic logic [XW-1:0] model_tgt(input logic [XW-1:0] a, input logic [11:0] i);
        logic [XW-1:0] t;
        int            s;
        s = $signed(i);
        t = a + XW'(s);
        t[0] = 1'b0;
        if (t[XW-1:VW] != {(XW-VW){t[VW-1]}})
            t = {{(XW-VW){t[VW-1]}}, t[VW-1:0]};
        return t;
    endfunction

    task automatic run_one(input logic [XW-1:0] a, input logic [XW-1:0] b,
                           input logic [XW-1:0] t, input logic [11:0] i,
                           input logic tg, input logic sl, input logic [XW-1:0] pc);
        logic [XW-1:0] et;
        logic [1:0]    ec;
        et = model_tgt(a, i);
        if (!tg) ec = 2'b01;
        else if (et < b || ({1'b0, et} + 17'd4) > {1'b0, t}) ec = 2'b10;
        else ec = 2'b00;
        @(negedge clk);
        in_valid = 1'b1; src_addr = a; src_base = b; src_top = t;
        src_tag = tg; src_sealed = sl; imm = i;
        pcc_addr = pc; pcc_base = pc ^ 16'h00F0; pcc_top = pc ^ 16'h0F00;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "out_valid", 32'(out_valid), 32'd1);
        chk(ec == 2'b01 ? "R4" : "R3", "cause", 32'(out_cause), 32'(ec));
        chk(ec == 2'b01 ? "R4" : "R3", "exc", 32'(out_exc), 32'(ec != 2'b00));
        chk("R6", "pc_we", 32'(out_pc_we), 32'(ec == 2'b00));
        chk("R7", "link_we", 32'(out_link_we), 32'(ec == 2'b00));
        if (ec == 2'b00) begin
            chk(sl ? "R5" : "R1", "pc_addr", 32'(out_pc_addr), 32'(et));
            chk("R5", "pc_sealed", 32'(out_pc_sealed), 32'd0);
            chk("R6", "pc_base", 32'(out_pc_base), 32'(b));
            chk("R6", "pc_top", 32'(out_pc_top), 32'(t));
            chk("R7", "link_addr", 32'(out_link_addr), 32'(XW'(pc + 16'd4)));
            chk("R7", "link_base", 32'(out_link_base), 32'(pc ^ 16'h00F0));
            chk("R7", "link_top", 32'(out_link_top), 32'(pc ^ 16'h0F00));
            chk("R7", "link_sealed", 32'(out_link_sealed), 32'd1);
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [XW-1:0] sa [NSET] = '{16'h0100, 16'h01F0, 16'hFF00, 16'h0050, 16'h0000, 16'h3000};
        logic [XW-1:0] sb [NSET] = '{16'h0000, 16'h0100, 16'hFE00, 16'h0040, 16'h0000, 16'h0000};
        logic [XW-1:0] st [NSET] = '{16'h0400, 16'h0200, 16'hFFFF, 16'h0080, 16'hFFFF, 16'hFFFF};
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R8", "reset pc_we", 32'(out_pc_we), 32'd0);
        chk("R8", "reset link_we", 32'(out_link_we), 32'd0);
        chk("R8", "reset exc", 32'(out_exc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "idle out_valid", 32'(out_valid), 32'd0);
        // R2: a valid address passes through unchanged, an invalid one folds.
        run_one(16'h0010, 16'h0000, 16'hFFFF, 12'h000, 1'b1, 1'b0, 16'h1000);
        chk("R2", "valid unchanged", 32'(out_pc_addr), 32'h0010);
        run_one(16'h01FE, 16'h0000, 16'hFFFF, 12'h004, 1'b1, 1'b0, 16'h1000);
        chk("R2", "folded", 32'(out_pc_addr), 32'hFE02);
        // R4 over R3: tag clear and out of bounds together.
        run_one(16'h0100, 16'h0200, 16'h0300, 12'h000, 1'b0, 1'b0, 16'h2000);
        chk("R4", "priority cause", 32'(out_cause), 32'h1);
        // R3: exact top edge, fits then one step beyond.
        run_one(16'h007C, 16'h0040, 16'h0080, 12'h000, 1'b1, 1'b0, 16'hFFFE);
        chk("R3", "fits at top", 32'(out_cause), 32'h0);
        run_one(16'h007E, 16'h0040, 16'h0080, 12'h002, 1'b1, 1'b0, 16'hFFFE);
        chk("R3", "past top", 32'(out_cause), 32'h2);
        @(negedge clk);
        chk("R8", "pulse drops", 32'(out_valid), 32'd0);
        for (int s = 0; s < NSET; s++) begin
            for (int i = 0; i < 4096; i++) begin
                run_one(sa[s], sb[s], st[s], 12'(i), (i % 7) != 0, i[1],
                        16'hFFF0 + 16'(i[3:0]));
            end
        end
        @(negedge clk);
        chk("R8", "final idle", 32'(out_valid), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule